// File: doc/BRIEF.md
# Backup Source Select and Isolation Controller

This block sequences the supply path of a battery-backed memory. It takes digitized comparator flags for the main supply, the two backup cells and the chip-enable line. From them it produces a registered source-select code and an isolation status. While the main supply is above the switch-over level, the memory is fed from the main supply. Below that level, the block picks a backup cell, preferring cell 1 while it holds above its minimum voltage and falling back to cell 2 otherwise. A cell that is not fitted reads as below threshold, so it is never chosen.

To stop a stored-away module from draining its batteries, the block can place the backup path in an isolated state, where no cell feeds the memory. Two things isolate it:
- a battery-attach event;
- a qualified isolation request, which is a sustained mid-level signal on the chip-enable line.

The request must arrive in the interval after the supply drops below its fail threshold and before it reaches the switch-over level. The request is judged at switch-over. The block leaves isolation the next time main power is applied, so the following power loss connects a battery again.

All flags are assumed already synchronous to `clk`. Both outputs change one clock after the inputs that cause them.

Top module: `bkp_source_ctrl`

## Requirements
- R1: A synchronous reset drives `src_sel_o` to 2'b00 and `isolated_o` to 1. The tracked power phase is treated as unpowered, so the next cycle with `supply_ok_i` high counts as a power application.
- R2: In every cycle with `supply_low_i` low, `src_sel_o` becomes 2'b01 (main supply) one clock later, whatever the isolation state.
- R3: With `supply_low_i` high and the block not isolated, `src_sel_o` becomes 2'b10 (cell 1) one clock later whenever `cell1_good_i` is high.
- R4: With `supply_low_i` high, the block not isolated and `cell1_good_i` low, `src_sel_o` becomes 2'b11 (cell 2) if `cell2_good_i` is high. If both cell flags are low it becomes 2'b00; a cell whose flag is low is never selected.
- R5: A high bit in `attach_evt_i` (bit 0 cell 1, bit 1 cell 2) sets `isolated_o` one clock later. While `supply_low_i` is high, it forces `src_sel_o` to 2'b00 in that same clock. This takes priority over every other cause.
- R6: A power application is a cycle with `supply_ok_i` high after a cycle in which it was low, or the first such cycle after reset. It clears `isolated_o` one clock later unless an attach event occurs in the same cycle.
- R7: The fail window is the span in which `supply_ok_i` and `supply_low_i` are both low and switch-over has not yet been reached since power was last valid. If `ce_mid_i` is high for `QUAL_CYCLES` consecutive cycles inside the window, and `ce_over_i` is never high in it, the block isolates. Isolation takes effect in the clock where `supply_low_i` is first seen high, and `src_sel_o` is 2'b00 from that clock on. `QUAL_CYCLES` is 35 at the default 20 ns clock.
- R8: A mid-level run shorter than `QUAL_CYCLES` consecutive window cycles does not qualify. Any cycle with `ce_mid_i` low restarts the count.
- R9: A single window cycle with `ce_over_i` high cancels the request for that power-down, even after the request has qualified.
- R10: `ce_mid_i` and `ce_over_i` have no effect outside the fail window, whether the main supply is valid or the block is already on backup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok_i | input | 1 | Main supply above fail threshold |
| supply_low_i | input | 1 | Main supply below switch-over level |
| cell1_good_i | input | 1 | Cell 1 above its minimum voltage |
| cell2_good_i | input | 1 | Cell 2 present and usable |
| attach_evt_i | input | 2 | One-cycle battery-attach pulses, bit 0 cell 1, bit 1 cell 2 |
| ce_mid_i | input | 1 | Chip-enable line inside the mid-level band |
| ce_over_i | input | 1 | Chip-enable line above the cancel limit |
| src_sel_o | output | 2 | 00 none/isolated, 01 main, 10 cell 1, 11 cell 2 |
| isolated_o | output | 1 | Backup path isolated |

## Verification
Outage sequences walk the source choice through every combination of the two cell flags. This separates the cell-1 preference from the cell-2 fallback and the no-source code. Power-downs carry a full-length mid-level run, a run split by a one-cycle gap and a full run spoiled by one over-limit cycle. Together they show that isolation needs an unbroken run and no cancellation. Mid-level runs placed while powered and during backup show the window gating. Attach pulses before and during an outage, followed by a power cycle, tell the attach path apart from the reconnect on power application.

// File: rtl/bkp_pkg.sv
package bkp_pkg;
  typedef enum logic [1:0] {
    SRC_NONE  = 2'b00,
    SRC_MAIN  = 2'b01,
    SRC_CELL1 = 2'b10,
    SRC_CELL2 = 2'b11
  } src_e;

  typedef enum logic [1:0] {
    PH_ON     = 2'b00,
    PH_FALL   = 2'b01,
    PH_BACKUP = 2'b10
  } phase_e;
endpackage

// File: rtl/bkp_phase_tracker.sv
module bkp_phase_tracker
  import bkp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic supply_ok_i,
  input  logic supply_low_i,
  output logic win_o,
  output logic pwr_apply_o,
  output logic judge_o
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (supply_ok_i)            phase_d = PH_ON;
    else if (supply_low_i)      phase_d = PH_BACKUP;
    else if (phase_q == PH_ON)  phase_d = PH_FALL;
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_BACKUP;
    else     phase_q <= phase_d;
  end

  // power just became valid after any unpowered phase
  assign pwr_apply_o = supply_ok_i && (phase_q != PH_ON);
  // switch-over reached from inside the fail window
  assign judge_o     = supply_low_i && (phase_q == PH_FALL);
  // between fail threshold and switch-over on the way down
  assign win_o       = !supply_ok_i && !supply_low_i && (phase_q != PH_BACKUP);

  // R6
  phase_after_apply_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_apply_o |=> !judge_o || !supply_ok_i);
endmodule

// File: rtl/bkp_iso_qualifier.sv
module bkp_iso_qualifier #(
  parameter int QUAL_CYCLES = 35
) (
  input  logic clk,
  input  logic rst,
  input  logic win_i,
  input  logic ce_mid_i,
  input  logic ce_over_i,
  output logic req_ok_o
);
  localparam int CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          qual_q, cancel_q;

  always_ff @(posedge clk) begin
    if (rst || !win_i) begin
      cnt_q    <= '0;
      qual_q   <= 1'b0;
      cancel_q <= 1'b0;
    end else begin
      if (ce_over_i) cancel_q <= 1'b1;
      if (ce_mid_i) begin
        if (cnt_q == LAST) qual_q <= 1'b1;
        else               cnt_q  <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign req_ok_o = qual_q && !cancel_q;

  // R8
  qual_needs_mid_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(qual_q) |-> $past(ce_mid_i));

  // R9
  over_cancels_chk: assert property (@(posedge clk) disable iff (rst)
    (win_i && ce_over_i) |=> !req_ok_o || !win_i);
endmodule

// File: rtl/bkp_source_mux.sv
module bkp_source_mux
  import bkp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       attach_i,
  input  logic       pwr_apply_i,
  input  logic       judge_i,
  input  logic       req_ok_i,
  input  logic       supply_low_i,
  input  logic       cell1_good_i,
  input  logic       cell2_good_i,
  output logic [1:0] sel_o,
  output logic       iso_o
);
  logic iso_q, iso_d;
  src_e sel_q, sel_d;

  always_comb begin
    iso_d = iso_q;
    if (attach_i)                iso_d = 1'b1;
    else if (pwr_apply_i)        iso_d = 1'b0;
    else if (judge_i && req_ok_i) iso_d = 1'b1;
  end

  always_comb begin
    if (!supply_low_i)     sel_d = SRC_MAIN;
    else if (iso_d)        sel_d = SRC_NONE;
    else if (cell1_good_i) sel_d = SRC_CELL1;
    else if (cell2_good_i) sel_d = SRC_CELL2;
    else                   sel_d = SRC_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iso_q <= 1'b1;
      sel_q <= SRC_NONE;
    end else begin
      iso_q <= iso_d;
      sel_q <= sel_d;
    end
  end

  assign sel_o = sel_q;
  assign iso_o = iso_q;

  // R2
  main_when_up_chk: assert property (@(posedge clk) disable iff (rst)
    !supply_low_i |=> sel_o == SRC_MAIN);

  // R5
  attach_isolates_chk: assert property (@(posedge clk) disable iff (rst)
    attach_i |=> iso_o);

  // R5
  attach_blocks_cells_chk: assert property (@(posedge clk) disable iff (rst)
    (attach_i && supply_low_i) |=> sel_o == SRC_NONE);

  // R6
  apply_reconnects_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_apply_i && !attach_i) |=> !iso_o);
endmodule

// File: rtl/bkp_source_ctrl.sv
module bkp_source_ctrl
  import bkp_pkg::*;
#(
  parameter int CLK_NS  = 20,
  parameter int QUAL_NS = 700
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       supply_ok_i,
  input  logic       supply_low_i,
  input  logic       cell1_good_i,
  input  logic       cell2_good_i,
  input  logic [1:0] attach_evt_i,
  input  logic       ce_mid_i,
  input  logic       ce_over_i,
  output logic [1:0] src_sel_o,
  output logic       isolated_o
);
  localparam int QUAL_CYCLES = (QUAL_NS + CLK_NS - 1) / CLK_NS;

  logic win, pwr_apply, judge, req_ok;

  bkp_phase_tracker u_phase (
    .clk         (clk),
    .rst         (rst),
    .supply_ok_i (supply_ok_i),
    .supply_low_i(supply_low_i),
    .win_o       (win),
    .pwr_apply_o (pwr_apply),
    .judge_o     (judge)
  );

  bkp_iso_qualifier #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk      (clk),
    .rst      (rst),
    .win_i    (win),
    .ce_mid_i (ce_mid_i),
    .ce_over_i(ce_over_i),
    .req_ok_o (req_ok)
  );

  bkp_source_mux u_mux (
    .clk         (clk),
    .rst         (rst),
    .attach_i    (|attach_evt_i),
    .pwr_apply_i (pwr_apply),
    .judge_i     (judge),
    .req_ok_i    (req_ok),
    .supply_low_i(supply_low_i),
    .cell1_good_i(cell1_good_i),
    .cell2_good_i(cell2_good_i),
    .sel_o       (src_sel_o),
    .iso_o       (isolated_o)
  );

  // R7
  no_cell_when_iso_chk: assert property (@(posedge clk) disable iff (rst)
    isolated_o |-> (src_sel_o == SRC_NONE || src_sel_o == SRC_MAIN));
endmodule

// File: tb/bkp_source_ctrl_test.sv
module bkp_source_ctrl_test;
  localparam int Q = 35;

  logic clk = 1'b0, rst = 1'b1;
  logic ok = 1'b0, low = 1'b1, c1 = 1'b0, c2 = 1'b0, mid = 1'b0, over = 1'b0;
  logic [1:0] att = 2'b00;
  logic [1:0] sel;
  logic iso;

  int tests = 0, fails = 0;
  string req = "R1";

  int m_state, m_iso, m_sel, m_cnt, m_qual, m_cancel;
  bit done = 0;

  always #10 clk = ~clk;

  bkp_source_ctrl uut (
    .clk(clk), .rst(rst), .supply_ok_i(ok), .supply_low_i(low),
    .cell1_good_i(c1), .cell2_good_i(c2), .attach_evt_i(att),
    .ce_mid_i(mid), .ce_over_i(over), .src_sel_o(sel), .isolated_o(iso)
  );

  // behavioural reference, 0 on / 1 falling / 2 backup
  always @(posedge clk) begin
    bit pwr, judge, win;
    int ni;
    if (rst) begin
      m_state = 2; m_iso = 1; m_sel = 0; m_cnt = 0; m_qual = 0; m_cancel = 0;
    end else begin
      pwr   = ok && m_state != 0;
      judge = low && m_state == 1;
      win   = !ok && !low && m_state != 2;
      ni = m_iso;
      if (att != 0) ni = 1;
      else if (pwr) ni = 0;
      else if (judge && m_qual == 1 && m_cancel == 0) ni = 1;
      if (!low) m_sel = 1;
      else if (ni == 1) m_sel = 0;
      else if (c1) m_sel = 2;
      else if (c2) m_sel = 3;
      else m_sel = 0;
      m_iso = ni;
      if (win) begin
        if (over) m_cancel = 1;
        if (mid) begin
          if (m_cnt >= Q - 1) m_qual = 1; else m_cnt++;
        end else m_cnt = 0;
      end else begin
        m_cnt = 0; m_qual = 0; m_cancel = 0;
      end
      if (ok) m_state = 0;
      else if (low) m_state = 2;
      else if (m_state == 0) m_state = 1;
    end
    #2;
    if (!rst && !done) begin
      tests++;
      if (int'(sel) != m_sel || int'(iso) != m_iso) begin
        fails++;
        $display("FAIL %s model: sel=%0d iso=%0d expected sel=%0d iso=%0d",
                 req, sel, iso, m_sel, m_iso);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int es, input int ei);
    tests++;
    if (int'(sel) != es || int'(iso) != ei) begin
      fails++;
      $display("FAIL %s: sel=%0d iso=%0d expected sel=%0d iso=%0d", tag, sel, iso, es, ei);
    end
  endtask

  task automatic power_up;
    ok = 1; low = 0; step(3);
  endtask

  task automatic fall(input int n);
    ok = 0; low = 0; step(n);
  endtask

  task automatic mid_run(input int n);
    mid = 1; step(n); mid = 0;
  endtask

  initial begin
    step(3);
    chk("R1 reset", 0, 1);
    rst = 0;
    c1 = 1; c2 = 1;
    step(1);
    chk("R1 held unpowered", 0, 1);

    req = "R6"; power_up;
    chk("R6 apply clears isolation", 1, 0);
    req = "R2"; chk("R2 main selected", 1, 0);

    req = "R3"; fall(4); chk("R2 main in window", 1, 0);
    low = 1; step(2); chk("R3 cell1", 2, 0);
    req = "R4"; c1 = 0; step(2); chk("R4 cell2 fallback", 3, 0);
    c2 = 0; step(2); chk("R4 no usable cell", 0, 0);
    c1 = 1; c2 = 1; step(2); chk("R3 cell1 restored", 2, 0);

    req = "R7"; power_up; fall(2); mid_run(Q + 5); fall(2);
    low = 1; step(1); chk("R7 qualified isolation", 0, 1);
    step(3); chk("R7 stays isolated", 0, 1);
    power_up; chk("R6 reconnect on apply", 1, 0);

    req = "R7"; fall(2); mid_run(Q); fall(1);
    low = 1; step(1); chk("R7 exact length", 0, 1);
    power_up;

    req = "R8"; fall(2); mid_run(Q - 1); fall(3);
    low = 1; step(2); chk("R8 one short", 2, 0);
    power_up;
    fall(2); mid_run(20); fall(1); mid_run(20); fall(2);
    low = 1; step(2); chk("R8 split run", 2, 0);
    power_up;

    req = "R9"; fall(2); mid_run(Q + 5); over = 1; step(1); over = 0; fall(2);
    low = 1; step(2); chk("R9 cancel after qualify", 2, 0);
    power_up;
    fall(2); over = 1; step(1); over = 0; mid_run(Q + 5);
    low = 1; step(2); chk("R9 cancel before run", 2, 0);
    power_up;

    req = "R10"; mid_run(Q + 10); fall(2);
    low = 1; step(2); chk("R10 mid while powered", 2, 0);
    mid_run(Q + 10); low = 0; step(2); low = 1; step(2);
    chk("R10 mid during backup", 2, 0);
    power_up;

    req = "R5"; fall(2); low = 1; step(2); chk("R5 pre-attach cell1", 2, 0);
    att = 2'b10; step(1); att = 2'b00; chk("R5 attach isolates", 0, 1);
    step(3); chk("R5 isolation held", 0, 1);
    att = 2'b01; power_up; att = 2'b00; chk("R5 attach beats apply", 1, 1);
    fall(2); low = 1; step(2); chk("R5 isolated through outage", 0, 1);
    req = "R6"; power_up; fall(2); low = 1; step(2); chk("R6 battery after cycle", 2, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: sel=%0d iso=%0d expected run to finish", sel, iso);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule